// File: doc/BRIEF.md
# Interval Timer Host Register Interface

This block is the byte-wide register front end of a three-channel interval timer. A host drives a 2-bit address with separate read and write strobes. Addresses 0, 1 and 2 are the data ports of the three counter channels, and address 3 takes control words. A control word either reprograms one channel's operating mode and byte-access style, or asks that channel to freeze a snapshot of its live count.

Each channel keeps a byte pointer for writes and another for reads. Multi-byte values can then move through a single non-incrementing port, low byte first. When a high byte completes a preset, the channel's count-down engine gets a one-cycle load strobe. When a channel is reprogrammed, the engine gets a one-cycle clear strobe. A frozen snapshot stays in place until the host has read all of it, so the two halves of one reading always belong together while the live counter keeps running. The count-down engines are outside this block. They take the mode, preset and strobes, and they return their live counts on `count_i`.

Top module: `ptimer_host_if`

## Requirements
- R1: After reset every channel reports mode 0, binary counting, preset 0, two-byte access and both byte pointers on the low byte. No snapshot is held, `rdata_o` is 0, and no load or clear strobe is raised.
- R2: A write to address 3 is a control word. Bits [7:6] select the channel, bits [5:4] select the access style (00 latch, 01 low byte only, 10 high byte only, 11 low then high), bits [3:1] give the operating mode and bit 0 gives BCD select. A channel select of 3 changes nothing.
- R3: A control word with access style other than 00 stores the mode, BCD bit and access style. In the next cycle it shows a preset of 0 and a one-cycle `clear_o` pulse for that channel. It also returns both byte pointers to the low byte and drops any held snapshot.
- R4: Mode codes 6 and 7 are stored as 2 and 3. Codes 0 to 5 are stored unchanged.
- R5: With access style 11, the first data write stores a pending low byte and leaves `preset_o` and `load_o` unchanged. The second write sets `preset_o` to {second, first} and raises `load_o` for exactly one cycle, both in the cycle after that write.
- R6: With access style 01, each data write sets the preset to {0, data}. With 10, each write sets it to {data, 0}. Each such write raises `load_o` for one cycle.
- R7: A control word with access style 00 captures the channel's `count_i` value in the write cycle and leaves mode and access style unchanged. Reads of that channel then return bytes of the snapshot, whatever `count_i` does.
- R8: While a snapshot is held, another latch command to that channel does not change the snapshot or the read pointer. The snapshot is released after its last byte is read (the high byte for style 11, the single byte for 01 or 10). Reads after that return live counts, and a later latch captures anew.
- R9: `rdata_o` changes only in the cycle after a read strobe and holds otherwise. With no snapshot held, style 11 reads alternate between the low and high byte of the live count, style 01 always returns the low byte and style 10 always returns the high byte.
- R10: A read of address 3 returns 0.
- R11: Any control word that addresses a channel returns its write pointer to the low byte, including a latch command that is ignored. A pending low byte is therefore discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Register address: 0..2 channel data, 3 control |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, registered, valid the cycle after `rd_i` |
| count_i | input | 48 | Live count of each channel, 16 bits per channel, channel 0 in the low bits |
| mode_o | output | 9 | Operating mode of each channel, 3 bits per channel |
| bcd_o | output | 3 | Stored BCD select bit of each channel |
| preset_o | output | 48 | Stored preset of each channel, 16 bits per channel |
| load_o | output | 3 | One-cycle strobe per channel: preset complete |
| clear_o | output | 3 | One-cycle strobe per channel: channel reprogrammed, count cleared |

## Verification
The bench builds the block with its default parameters: three channels and 8-bit data, so 16-bit counts. At this size every channel can be swept through all eight mode codes with every access style, which reaches the 6 and 7 mode folding and the no-op channel select. A free-running down-counter stub on each channel means every latch and live read is checked against a count that keeps moving. That exposes any snapshot taken in the wrong cycle or released too early. Interleaved orders, such as a latch between the two halves of a preset or between the two halves of a read, exercise the pointer resets and the ignored second latch.

// File: rtl/ptimer_pkg.sv
package ptimer_pkg;
  typedef enum logic [1:0] {
    ACC_LATCH = 2'b00,
    ACC_LO    = 2'b01,
    ACC_HI    = 2'b10,
    ACC_WORD  = 2'b11
  } acc_e;

  // codes 6 and 7 alias onto 2 and 3
  function automatic logic [2:0] norm_mode(input logic [2:0] f);
    return f[1] ? {1'b0, f[1:0]} : f;
  endfunction
endpackage

// File: rtl/ptimer_ctl_decode.sv
module ptimer_ctl_decode #(
  parameter int NUM_CH = 3
) (
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [1:0]        addr_i,
  input  logic [7:0]        wdata_i,
  output logic [NUM_CH-1:0] latch_o,
  output logic [NUM_CH-1:0] prog_o,
  output logic [NUM_CH-1:0] dwr_o,
  output logic [NUM_CH-1:0] drd_o,
  output ptimer_pkg::acc_e  acc_o,
  output logic [2:0]        mode_o,
  output logic              bcd_o
);
  logic ctl_wr;
  assign ctl_wr = wr_i && (addr_i == 2'd3);
  assign acc_o  = ptimer_pkg::acc_e'(wdata_i[5:4]);
  assign mode_o = wdata_i[3:1];
  assign bcd_o  = wdata_i[0];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_dec
    logic hit;
    assign hit        = ctl_wr && (wdata_i[7:6] == 2'(g));
    assign latch_o[g] = hit && (wdata_i[5:4] == 2'b00);
    assign prog_o[g]  = hit && (wdata_i[5:4] != 2'b00);
    assign dwr_o[g]   = wr_i && (addr_i == 2'(g));
    assign drd_o[g]   = rd_i && (addr_i == 2'(g));
  end
endmodule

// File: rtl/ptimer_chan_regs.sv
module ptimer_chan_regs #(
  parameter int DATA_W = 8,
  localparam int CNT_W = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              latch_i,
  input  logic              prog_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  ptimer_pkg::acc_e  acc_i,
  input  logic [2:0]        mode_i,
  input  logic              bcd_i,
  input  logic [CNT_W-1:0]  count_i,
  output logic [2:0]        mode_o,
  output logic              bcd_o,
  output logic [CNT_W-1:0]  preset_o,
  output logic              load_o,
  output logic              clear_o,
  output logic [DATA_W-1:0] rbyte_o
);
  import ptimer_pkg::*;

  acc_e              acc_q;
  logic [2:0]        mode_q;
  logic              bcd_q;
  logic [CNT_W-1:0]  preset_q, snap_q;
  logic [DATA_W-1:0] lo_q;
  logic              wptr_q, rptr_q, held_q, load_q, clear_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q    <= ACC_WORD;
      mode_q   <= '0;
      bcd_q    <= 1'b0;
      preset_q <= '0;
      snap_q   <= '0;
      lo_q     <= '0;
      wptr_q   <= 1'b0;
      rptr_q   <= 1'b0;
      held_q   <= 1'b0;
      load_q   <= 1'b0;
      clear_q  <= 1'b0;
    end else begin
      load_q  <= 1'b0;
      clear_q <= 1'b0;
      if (prog_i) begin
        mode_q   <= norm_mode(mode_i);
        bcd_q    <= bcd_i;
        acc_q    <= acc_i;
        preset_q <= '0;
        clear_q  <= 1'b1;
        wptr_q   <= 1'b0;
        rptr_q   <= 1'b0;
        held_q   <= 1'b0;
      end else begin
        if (latch_i) begin
          wptr_q <= 1'b0;
          if (!held_q) begin
            held_q <= 1'b1;
            snap_q <= count_i;
            rptr_q <= 1'b0;
          end
        end
        if (wr_i) begin
          unique case (acc_q)
            ACC_LO: begin
              preset_q <= {{DATA_W{1'b0}}, wdata_i};
              load_q   <= 1'b1;
            end
            ACC_HI: begin
              preset_q <= {wdata_i, {DATA_W{1'b0}}};
              load_q   <= 1'b1;
            end
            ACC_WORD: begin
              if (!wptr_q) begin
                lo_q   <= wdata_i;
                wptr_q <= 1'b1;
              end else begin
                preset_q <= {wdata_i, lo_q};
                load_q   <= 1'b1;
                wptr_q   <= 1'b0;
              end
            end
            default: ;
          endcase
        end
        if (rd_i) begin
          if (acc_q == ACC_WORD) begin
            rptr_q <= !rptr_q;
            if (rptr_q) held_q <= 1'b0;
          end else begin
            held_q <= 1'b0;
          end
        end
      end
    end
  end

  logic [CNT_W-1:0] src;
  logic             hi_sel;
  assign src     = held_q ? snap_q : count_i;
  assign hi_sel  = (acc_q == ACC_HI) || ((acc_q == ACC_WORD) && rptr_q);
  assign rbyte_o = hi_sel ? src[CNT_W-1:DATA_W] : src[DATA_W-1:0];

  assign mode_o   = mode_q;
  assign bcd_o    = bcd_q;
  assign preset_o = preset_q;
  assign load_o   = load_q;
  assign clear_o  = clear_q;
endmodule

// File: rtl/ptimer_host_if.sv
module ptimer_host_if #(
  parameter int NUM_CH = 3,
  parameter int DATA_W = 8,
  localparam int CNT_W = 2 * DATA_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [1:0]              addr_i,
  input  logic                    wr_i,
  input  logic                    rd_i,
  input  logic [7:0]              wdata_i,
  output logic [DATA_W-1:0]       rdata_o,
  input  logic [NUM_CH*CNT_W-1:0] count_i,
  output logic [NUM_CH*3-1:0]     mode_o,
  output logic [NUM_CH-1:0]       bcd_o,
  output logic [NUM_CH*CNT_W-1:0] preset_o,
  output logic [NUM_CH-1:0]       load_o,
  output logic [NUM_CH-1:0]       clear_o
);
  logic [NUM_CH-1:0] latch_w, prog_w, dwr_w, drd_w;
  ptimer_pkg::acc_e  acc_w;
  logic [2:0]        mode_w;
  logic              bcd_w;
  logic [DATA_W-1:0] rbyte_w [NUM_CH];

  ptimer_ctl_decode #(.NUM_CH(NUM_CH)) u_dec (
    .wr_i   (wr_i),
    .rd_i   (rd_i),
    .addr_i (addr_i),
    .wdata_i(wdata_i),
    .latch_o(latch_w),
    .prog_o (prog_w),
    .dwr_o  (dwr_w),
    .drd_o  (drd_w),
    .acc_o  (acc_w),
    .mode_o (mode_w),
    .bcd_o  (bcd_w)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    ptimer_chan_regs #(.DATA_W(DATA_W)) u_ch (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .latch_i (latch_w[g]),
      .prog_i  (prog_w[g]),
      .wr_i    (dwr_w[g]),
      .rd_i    (drd_w[g]),
      .wdata_i (wdata_i[DATA_W-1:0]),
      .acc_i   (acc_w),
      .mode_i  (mode_w),
      .bcd_i   (bcd_w),
      .count_i (count_i[g*CNT_W +: CNT_W]),
      .mode_o  (mode_o[g*3 +: 3]),
      .bcd_o   (bcd_o[g]),
      .preset_o(preset_o[g*CNT_W +: CNT_W]),
      .load_o  (load_o[g]),
      .clear_o (clear_o[g]),
      .rbyte_o (rbyte_w[g])
    );
  end

  logic [DATA_W-1:0] sel_byte;
  always_comb begin
    sel_byte = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (addr_i == 2'(i)) sel_byte = rbyte_w[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (rd_i) rdata_o <= sel_byte;
  end
endmodule

// File: rtl/ptimer_host_if_chk.sv
module ptimer_host_if_chk #(
  parameter int NUM_CH = 3,
  parameter int DATA_W = 8,
  localparam int CNT_W = 2 * DATA_W
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic [1:0]              addr_i,
  input logic                    wr_i,
  input logic                    rd_i,
  input logic [7:0]              wdata_i,
  input logic [DATA_W-1:0]       rdata_o,
  input logic [NUM_CH*3-1:0]     mode_o,
  input logic [NUM_CH*CNT_W-1:0] preset_o,
  input logic [NUM_CH-1:0]       load_o,
  input logic [NUM_CH-1:0]       clear_o
);
  assert_nop_select_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == 2'd3 && wdata_i[7:6] == 2'd3) |=> (clear_o == '0));

  assert_ctl_read_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == 2'd3) |=> (rdata_o == '0));

  assert_rdata_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    assert_prog_clears_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && addr_i == 2'd3 && wdata_i[7:6] == 2'(g) && wdata_i[5:4] != 2'b00)
      |=> (clear_o[g] && preset_o[g*CNT_W +: CNT_W] == '0));

    assert_mode_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mode_o[g*3 +: 3] < 3'd6);

    assert_load_from_port_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      load_o[g] |-> $past(wr_i && addr_i == 2'(g)));

    assert_preset_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!load_o[g] && !clear_o[g]) |-> $stable(preset_o[g*CNT_W +: CNT_W]));
  end
endmodule

bind ptimer_host_if ptimer_host_if_chk #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/ptimer_host_if_bench.sv
module ptimer_host_if_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [47:0] count;
  logic [8:0]  mode;
  logic [2:0]  bcd, load, clear;
  logic [47:0] preset;

  int vecs = 0, errs = 0;
  logic [15:0] cnt [NCH];
  logic [15:0] cap [NCH];

  always #(CLK_PERIOD/2) clk = !clk;

  ptimer_host_if u_ptimer_host_if (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .count_i(count), .mode_o(mode),
    .bcd_o(bcd), .preset_o(preset), .load_o(load), .clear_o(clear)
  );

  // stub count-down engines
  for (genvar g = 0; g < NCH; g++) begin : g_stub
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt[g] <= 16'h1357 * 16'(g + 1);
      else if (clear[g]) cnt[g] <= '0;
      else if (load[g])  cnt[g] <= preset[g*16 +: 16];
      else               cnt[g] <= cnt[g] - 16'd1;
    end
    assign count[g*16 +: 16] = cnt[g];
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    for (int i = 0; i < NCH; i++) cap[i] = cnt[i];
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    addr = a; rd = 1'b1;
    for (int i = 0; i < NCH; i++) cap[i] = cnt[i];
    @(negedge clk);
    rd = 1'b0;
    v = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] cw(input int ch, input int acc, input int m, input int b);
    return {2'(ch), 2'(acc), 3'(m), 1'(b)};
  endfunction

  function automatic logic [15:0] pre(input int ch);
    return preset[ch*16 +: 16];
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL watchdog actual=%0d expected=0", 1);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    logic [7:0]  v, v2;
    logic [15:0] snap, exp16;
    logic [15:0] vals [5];
    vals = '{16'h0000, 16'hFFFF, 16'h1234, 16'hA55A, 16'h0100};

    idle(3);
    #1 rst_n = 1'b1;
    idle(1);

    // R1 reset state
    for (int ch = 0; ch < NCH; ch++) begin
      chk(mode[ch*3 +: 3] == 0, "R1 mode", 32'(mode[ch*3 +: 3]), 0);
      chk(pre(ch) == 0, "R1 preset", 32'(pre(ch)), 0);
    end
    chk(bcd == 0 && load == 0 && clear == 0, "R1 strobes", {bcd, load, clear}, 0);
    chk(rdata == 0, "R1 rdata", 32'(rdata), 0);

    // R3 R4: every channel, every mode code, alternate BCD bit
    for (int ch = 0; ch < NCH; ch++)
      for (int m = 0; m < 8; m++) begin
        int em;
        em = (m >= 6) ? m - 4 : m;
        bus_wr(2'd3, cw(ch, 3, m, m % 2));
        chk(mode[ch*3 +: 3] == 3'(em), "R4 mode fold", 32'(mode[ch*3 +: 3]), em);
        chk(bcd[ch] == 1'(m % 2), "R3 bcd", 32'(bcd[ch]), m % 2);
        chk(clear == 3'(1 << ch), "R3 clear pulse", 32'(clear), 1 << ch);
        chk(pre(ch) == 0, "R3 preset zero", 32'(pre(ch)), 0);
        idle(1);
        chk(clear == 0, "R3 clear one cycle", 32'(clear), 0);
      end

    // R5 two-byte preset writes
    for (int ch = 0; ch < NCH; ch++)
      for (int k = 0; k < 5; k++) begin
        bus_wr(2'd3, cw(ch, 3, 2, 0));
        bus_wr(2'(ch), vals[k][7:0]);
        chk(load == 0 && pre(ch) == 0, "R5 low byte only", {load, pre(ch)}, 0);
        bus_wr(2'(ch), vals[k][15:8]);
        chk(load == 3'(1 << ch), "R5 load strobe", 32'(load), 1 << ch);
        chk(pre(ch) == vals[k], "R5 preset word", 32'(pre(ch)), 32'(vals[k]));
        idle(1);
        chk(load == 0, "R5 load one cycle", 32'(load), 0);
      end

    // R6 single-byte styles
    for (int ch = 0; ch < NCH; ch++) begin
      bus_wr(2'd3, cw(ch, 1, 0, 0));
      for (int d = 1; d < 256; d += 85) begin
        bus_wr(2'(ch), 8'(d));
        chk(load == 3'(1 << ch) && pre(ch) == 16'(d), "R6 low-only", 32'(pre(ch)), d);
      end
      bus_wr(2'd3, cw(ch, 2, 0, 0));
      for (int d = 1; d < 256; d += 85) begin
        bus_wr(2'(ch), 8'(d));
        chk(load == 3'(1 << ch) && pre(ch) == {8'(d), 8'h00}, "R6 high-only", 32'(pre(ch)), d << 8);
      end
    end

    // R2 channel select 3 is a no-op
    begin
      logic [8:0]  m0;
      logic [47:0] p0;
      m0 = mode; p0 = preset;
      bus_wr(2'd3, 8'hF6);
      chk(clear == 0 && mode == m0 && preset == p0, "R2 select 3 no-op", 32'(mode), 32'(m0));
    end

    // R7 latch freezes snapshot; mode unchanged
    for (int ch = 0; ch < NCH; ch++) begin
      bus_wr(2'd3, cw(ch, 3, 3, 0));
      bus_wr(2'(ch), 8'h00);
      bus_wr(2'(ch), 8'h80);
      idle(4);
      bus_wr(2'd3, cw(ch, 0, 5, 1));
      snap = cap[ch];
      chk(mode[ch*3 +: 3] == 3, "R7 mode kept", 32'(mode[ch*3 +: 3]), 3);
      idle(5);
      bus_rd(2'(ch), v);
      chk(v == snap[7:0], "R7 latched low", 32'(v), 32'(snap[7:0]));
      idle(3);
      bus_rd(2'(ch), v);
      chk(v == snap[15:8], "R7 latched high", 32'(v), 32'(snap[15:8]));
    end

    // R8 second latch ignored, release after last byte
    bus_wr(2'd3, cw(1, 0, 0, 0));
    snap = cap[1];
    idle(3);
    bus_wr(2'd3, cw(1, 0, 0, 0));
    bus_rd(2'd1, v);
    chk(v == snap[7:0], "R8 ignored latch low", 32'(v), 32'(snap[7:0]));
    bus_wr(2'd3, cw(1, 0, 0, 0));
    bus_rd(2'd1, v);
    chk(v == snap[15:8], "R8 ignored latch high", 32'(v), 32'(snap[15:8]));
    idle(2);
    bus_wr(2'd3, cw(1, 0, 0, 0));
    snap = cap[1];
    idle(2);
    bus_rd(2'd1, v);
    bus_rd(2'd1, v2);
    chk({v2, v} == snap, "R8 fresh latch", 32'({v2, v}), 32'(snap));

    // R9 live reads, style 11 alternating
    bus_rd(2'd1, v);
    exp16 = cap[1];
    chk(v == exp16[7:0], "R9 live low", 32'(v), 32'(exp16[7:0]));
    bus_rd(2'd1, v);
    exp16 = cap[1];
    chk(v == exp16[15:8], "R9 live high", 32'(v), 32'(exp16[15:8]));
    idle(3);
    chk(rdata == v, "R9 rdata hold", 32'(rdata), 32'(v));

    // R9 R8 single-byte styles, latch released by one read
    bus_wr(2'd3, cw(2, 1, 0, 0));
    idle(2);
    bus_wr(2'd3, cw(2, 0, 0, 0));
    snap = cap[2];
    idle(2);
    bus_rd(2'd2, v);
    chk(v == snap[7:0], "R8 low-only latched", 32'(v), 32'(snap[7:0]));
    bus_rd(2'd2, v);
    exp16 = cap[2];
    chk(v == exp16[7:0], "R9 low-only live", 32'(v), 32'(exp16[7:0]));
    bus_wr(2'd3, cw(2, 2, 0, 0));
    idle(1);
    for (int k = 0; k < 2; k++) begin
      bus_rd(2'd2, v);
      exp16 = cap[2];
      chk(v == exp16[15:8], "R9 high-only live", 32'(v), 32'(exp16[15:8]));
    end

    // R10 control address reads as zero
    bus_rd(2'd3, v);
    chk(v == 0, "R10 control read", 32'(v), 0);

    // R11 control word resets write pointer
    bus_wr(2'd3, cw(0, 3, 0, 0));
    bus_wr(2'd0, 8'hAA);
    bus_wr(2'd3, cw(0, 0, 0, 0));
    bus_wr(2'd0, 8'h11);
    chk(load == 0, "R11 latch reset pointer", 32'(load), 0);
    bus_wr(2'd0, 8'h22);
    chk(pre(0) == 16'h2211, "R11 latch reset pointer", 32'(pre(0)), 32'h2211);
    bus_wr(2'd0, 8'hBB);
    bus_wr(2'd3, cw(0, 3, 1, 0));
    bus_wr(2'd0, 8'h33);
    bus_wr(2'd0, 8'h44);
    chk(pre(0) == 16'h4433, "R11 program reset pointer", 32'(pre(0)), 32'h4433);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule